// File: doc/BRIEF.md
# USB Host Port Line-State Controller

This block decides what a host's downstream port puts on the wire at any moment: a bus reset (SE0), a resume (K), periodic frame activity, or nothing. Software owns three control bits. The bus reset bit is a level that software holds for as long as it wants the reset to last. The resume bit is a register that software sets and clears. Hardware can also set the resume bit by itself when a remote wakeup arrives from downstream and automatic wakeup is enabled. The bus-activity bit starts start-of-frame generation.

While activity is enabled, the block counts the frame interval from the clock. The interval is one full-speed frame or one high-speed micro-frame, chosen by a speed input. At every frame boundary the block raises a one-cycle send request for a downstream packet engine. When software clears the activity bit, the generator keeps running until it has issued one more send request, and only then lets the port go idle. Packet encoding and transmission are handled elsewhere.

Top module: `usbp_host_port`

## Requirements
- R1: After reset, `line_state` is idle (2'b00), `sof_req` is 0, `resume_bit` is 0 and `frame_run` is 0.
- R2: While `bus_rst_bit` is 1, `line_state` is SE0 (2'b01). It stays there as long as the bit is held, with no time limit inside the block.
- R3: A cycle with `resume_wr`=1 loads `resume_wdata` into `resume_bit` on the next cycle. A resume bit of 1 holds with no time limit until software writes 0. While it is 1 and no bus reset is active, `line_state` is K (2'b10).
- R4: When `auto_wake_en`=1 and `rwake_det`=1 in a cycle without a software write, `resume_bit` is 1 on the next cycle. When `auto_wake_en`=0, `rwake_det` has no effect on `resume_bit`.
- R5: If a software write and a qualified wakeup detection fall in the same cycle, the written value wins.
- R6: At full speed (`hs_sel`=0), the first `sof_req` pulse comes FS_CYCLES+1 cycles after the cycle in which `bus_act_bit` is first seen at 1. Later pulses come every FS_CYCLES cycles. Each pulse lasts one cycle.
- R7: At high speed (`hs_sel`=1), the same timing applies with HS_CYCLES in place of FS_CYCLES.
- R8: While frame generation runs, `frame_run` is 1 and `line_state` is active (2'b11). After `bus_act_bit` is cleared, exactly one more `sof_req` pulse is issued. `frame_run` drops in the same cycle as that pulse, and the port then shows idle.
- R9: No `sof_req` is issued while `bus_rst_bit` or `resume_bit` is 1. Once both are 0 again, the next pulse comes a full interval later.
- R10: Line priority is SE0 over K over active over idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst_bit | input | 1 | Software bus reset request (level) |
| resume_wr | input | 1 | Software write strobe for the resume bit |
| resume_wdata | input | 1 | Value written to the resume bit |
| auto_wake_en | input | 1 | Enables hardware setting of the resume bit on remote wakeup |
| rwake_det | input | 1 | Remote wakeup detected downstream |
| bus_act_bit | input | 1 | Software start-of-frame activity enable |
| hs_sel | input | 1 | 1 selects the high-speed micro-frame interval |
| line_state | output | 2 | 00 idle, 01 SE0, 10 K, 11 active |
| sof_req | output | 1 | One-cycle start-of-frame send request |
| resume_bit | output | 1 | Current resume bit, including hardware sets |
| frame_run | output | 1 | Frame generator running (includes the final drain frame) |

## Verification
The bench targets the graceful stop. A design that stops at once when activity is cleared issues no final pulse. A design that ignores the clear issues pulses forever.

It also holds reset and resume for far longer than a frame to expose any internal timeout. It checks that a suppressed boundary does not count as the drain frame; a design that got this wrong would drop `frame_run` without ever sending a request.

The bench drives wakeup with auto-wake disabled, and a software write coinciding with a detection, to catch a wrongly qualified or wrongly prioritised resume set. It measures the intervals at both speeds, which exposes off-by-one reload errors.

// File: rtl/usbp_pkg.sv
package usbp_pkg;

    typedef enum logic [1:0] {
        LS_IDLE   = 2'b00,
        LS_SE0    = 2'b01,
        LS_K      = 2'b10,
        LS_ACTIVE = 2'b11
    } line_e;

    typedef struct packed {
        logic run;
        logic sof;
    } seq_t;

endpackage

// File: rtl/usbp_frame_timer.sv
module usbp_frame_timer #(
    parameter int unsigned FS_CYCLES = 50000,
    parameter int unsigned HS_CYCLES = 6250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic blocked,
    input  logic hs_sel,
    output logic boundary
);
    localparam int unsigned W = (FS_CYCLES > HS_CYCLES) ? $clog2(FS_CYCLES) : $clog2(HS_CYCLES);
    localparam logic [W-1:0] FS_LAST = W'(FS_CYCLES - 1);
    localparam logic [W-1:0] HS_LAST = W'(HS_CYCLES - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [W-1:0] reload;
    logic         at_zero;

    always_comb begin
        tmr_d    = tmr_q;
        reload   = hs_sel ? HS_LAST : FS_LAST;
        at_zero  = (tmr_q.cnt == '0);
        boundary = run && !blocked && at_zero;
        // Idle or blocked: keep a full interval loaded
        if (!run || blocked || at_zero) begin
            tmr_d.cnt = reload;
        end else begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '{cnt: FS_LAST};
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/usbp_resume_reg.sv
module usbp_resume_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wdata,
    input  logic auto_en,
    input  logic det,
    output logic resume
);
    logic res_d, res_q;

    always_comb begin
        res_d = res_q;
        if (wr) begin
            res_d = wdata;
        end else if (auto_en && det) begin
            res_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= 1'b0;
        else        res_q <= res_d;
    end

    assign resume = res_q;
endmodule

// File: rtl/usbp_host_port.sv
module usbp_host_port
    import usbp_pkg::*;
#(
    parameter int unsigned FS_CYCLES = 50000,
    parameter int unsigned HS_CYCLES = 6250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_rst_bit,
    input  logic       resume_wr,
    input  logic       resume_wdata,
    input  logic       auto_wake_en,
    input  logic       rwake_det,
    input  logic       bus_act_bit,
    input  logic       hs_sel,
    output logic [1:0] line_state,
    output logic       sof_req,
    output logic       resume_bit,
    output logic       frame_run
);
    seq_t  seq_d, seq_q;
    logic  res_w;
    logic  blocked;
    logic  boundary;
    line_e line_w;

    usbp_resume_reg u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (resume_wr),
        .wdata   (resume_wdata),
        .auto_en (auto_wake_en),
        .det     (rwake_det),
        .resume  (res_w)
    );

    usbp_frame_timer #(
        .FS_CYCLES (FS_CYCLES),
        .HS_CYCLES (HS_CYCLES)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (seq_q.run),
        .blocked  (blocked),
        .hs_sel   (hs_sel),
        .boundary (boundary)
    );

    always_comb begin
        blocked = bus_rst_bit || res_w;
        seq_d   = seq_q;
        seq_d.sof = boundary;
        // Cleared enable: keep running until one frame request goes out
        seq_d.run = bus_act_bit || (seq_q.run && !boundary);

        if (bus_rst_bit)    line_w = LS_SE0;
        else if (res_w)     line_w = LS_K;
        else if (seq_q.run) line_w = LS_ACTIVE;
        else                line_w = LS_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{run: 1'b0, sof: 1'b0};
        else        seq_q <= seq_d;
    end

    assign line_state = line_w;
    assign sof_req    = seq_q.sof;
    assign resume_bit = res_w;
    assign frame_run  = seq_q.run;
endmodule

// File: rtl/usbp_host_port_chk.sv
module usbp_host_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_rst_bit,
    input logic       resume_wr,
    input logic       auto_wake_en,
    input logic       rwake_det,
    input logic [1:0] line_state,
    input logic       sof_req,
    input logic       resume_bit,
    input logic       frame_run
);
    assert_se0_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_bit |-> line_state == 2'b01);

    assert_resume_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_bit && !resume_wr) |=> resume_bit);

    assert_auto_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_wake_en && rwake_det && !resume_wr) |=> resume_bit);

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sof_req |=> !sof_req);

    assert_drain_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_run) |-> sof_req);

    assert_no_sof_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst_bit || resume_bit) |=> !sof_req);

    assert_k_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_bit && !bus_rst_bit) |-> line_state == 2'b10);
endmodule

bind usbp_host_port usbp_host_port_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_rst_bit  (bus_rst_bit),
    .resume_wr    (resume_wr),
    .auto_wake_en (auto_wake_en),
    .rwake_det    (rwake_det),
    .line_state   (line_state),
    .sof_req      (sof_req),
    .resume_bit   (resume_bit),
    .frame_run    (frame_run)
);

// File: tb/tb_usbp_host_port.sv
`timescale 1ns/1ps
module tb_usbp_host_port;
    localparam int FS = 24;
    localparam int HS = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rst_bit = 1'b0;
    logic       resume_wr = 1'b0;
    logic       resume_wdata = 1'b0;
    logic       auto_wake_en = 1'b0;
    logic       rwake_det = 1'b0;
    logic       bus_act_bit = 1'b0;
    logic       hs_sel = 1'b0;
    logic [1:0] line_state;
    logic       sof_req;
    logic       resume_bit;
    logic       frame_run;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    // behavioural reference state
    bit m_run = 0;
    bit m_res = 0;
    bit m_sof = 0;
    int m_el  = 0;

    always #10 clk = ~clk;

    usbp_host_port #(.FS_CYCLES(FS), .HS_CYCLES(HS)) dut (
        .clk(clk), .rst_n(rst_n), .bus_rst_bit(bus_rst_bit),
        .resume_wr(resume_wr), .resume_wdata(resume_wdata),
        .auto_wake_en(auto_wake_en), .rwake_det(rwake_det),
        .bus_act_bit(bus_act_bit), .hs_sel(hs_sel),
        .line_state(line_state), .sof_req(sof_req),
        .resume_bit(resume_bit), .frame_run(frame_run)
    );

    always @(posedge clk) begin
        bit blk, bnd, nrun, nres;
        int per;
        if (!rst_n) begin
            m_run = 0; m_res = 0; m_sof = 0; m_el = 0;
        end else begin
            per  = hs_sel ? HS : FS;
            blk  = bus_rst_bit || m_res;
            bnd  = m_run && !blk && (m_el == per - 1);
            nrun = bus_act_bit || (m_run && !bnd);
            if (resume_wr) nres = resume_wdata;
            else if (auto_wake_en && rwake_det) nres = 1;
            else nres = m_res;
            if (!m_run || blk || bnd) m_el = 0; else m_el = m_el + 1;
            m_sof = bnd; m_run = nrun; m_res = nres;
        end
    end

    function automatic int exp_line();
        if (bus_rst_bit) return 1;
        if (m_res)       return 2;
        if (m_run)       return 3;
        return 0;
    endfunction

    task automatic check(string tag, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: got %0d expected %0d", tag, cyc, got, exp);
        end
    endtask

    // one clock, then compare every output against the model
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        cyc++;
        check("R2 R3 R8 R10 line_state", int'(line_state), exp_line());
        check("R6 R7 R8 R9 sof_req", int'(sof_req), int'(m_sof));
        check("R3 R4 R5 resume_bit", int'(resume_bit), int'(m_res));
        check("R8 frame_run", int'(frame_run), int'(m_run));
    endtask

    task automatic run_count(int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            step();
            if (sof_req) pulses++;
        end
    endtask

    initial begin
        int p;
        int waited;
        repeat (3) @(negedge clk);
        check("R1 line_state", int'(line_state), 0);
        check("R1 sof_req", int'(sof_req), 0);
        check("R1 resume_bit", int'(resume_bit), 0);
        check("R1 frame_run", int'(frame_run), 0);
        rst_n = 1'b1;
        step();

        // full-speed frames
        bus_act_bit = 1'b1;
        run_count(80, p);
        check("R6 pulses in 80 cycles", p, 3);
        check("R8 active line", int'(line_state), 3);

        // graceful stop
        bus_act_bit = 1'b0;
        p = 0;
        waited = 0;
        while (frame_run && waited < 100) begin
            step();
            if (sof_req) p++;
            waited++;
        end
        check("R8 drain pulses", p, 1);
        run_count(30, p);
        check("R8 no pulse after drain", p, 0);
        check("R8 idle line", int'(line_state), 0);

        // high-speed micro-frames
        hs_sel = 1'b1;
        bus_act_bit = 1'b1;
        run_count(30, p);
        check("R7 pulses in 30 cycles", p, 4);
        bus_act_bit = 1'b0;
        run_count(10, p);
        hs_sel = 1'b0;
        run_count(3, p);

        // long bus reset during activity
        bus_act_bit = 1'b1;
        run_count(10, p);
        bus_rst_bit = 1'b1;
        run_count(60, p);
        check("R9 no pulse in reset", p, 0);
        check("R2 SE0 held", int'(line_state), 1);
        bus_rst_bit = 1'b0;
        run_count(26, p);
        check("R9 full interval after reset", p, 1);

        // resume by software, held long
        resume_wr = 1'b1; resume_wdata = 1'b1;
        step();
        resume_wr = 1'b0;
        run_count(60, p);
        check("R3 resume held", int'(resume_bit), 1);
        check("R9 no pulse in resume", p, 0);
        bus_rst_bit = 1'b1;
        step();
        check("R10 SE0 over K", int'(line_state), 1);
        bus_rst_bit = 1'b0;
        resume_wr = 1'b1; resume_wdata = 1'b0;
        step();
        resume_wr = 1'b0;
        check("R3 resume cleared", int'(resume_bit), 0);
        bus_act_bit = 1'b0;
        run_count(30, p);

        // wakeup detection, disabled then enabled
        rwake_det = 1'b1;
        step();
        rwake_det = 1'b0;
        step();
        check("R4 ignored when disabled", int'(resume_bit), 0);
        auto_wake_en = 1'b1;
        rwake_det = 1'b1;
        step();
        rwake_det = 1'b0;
        check("R4 hardware set", int'(resume_bit), 1);
        check("R4 K on wire", int'(line_state), 2);
        run_count(5, p);
        rwake_det = 1'b1; resume_wr = 1'b1; resume_wdata = 1'b0;
        step();
        rwake_det = 1'b0; resume_wr = 1'b0;
        check("R5 write beats detect", int'(resume_bit), 0);
        run_count(5, p);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule